// File: doc/BRIEF.md
# Translation Fault Syndrome Unit

This unit sits on a processor's memory request path, in front of the translation lookaside buffer. For each request it decides whether address translation is in force. Translation needs two things: the core must be configured with translation hardware, and the machine-state virtual-mode bit must be on. When translation is off, the address passes through unchanged. When it is on and the lookup succeeds with adequate permission, the unit forms the physical address from the matching entry. Otherwise it raises a memory-management exception. With that exception it records a syndrome word and the faulting address.

The lookup array lies outside this unit. It is seen only as a result port: hit, permission good, virtual page base and physical page base for the current request. The surrounding core supplies a flag saying a memory-management exception is already pending. A new fault that arrives while that flag is set is reported as an unrecoverable double fault. It does not become a second exception.

Top module: `mmu_fault_gen`

## Requirements
- R1: Translation is in force only when `cfg_mmu_present` is 1, `msr_vm` is 1, and either `cfg_full_set` is 0 or `cfg_xlat_field` equals 2'b11; otherwise the request takes the bypass path.
- R2: On the bypass path, `pa_valid` pulses one cycle after the request and `pa` equals the request address, with all bits unchanged.
- R3: When translation is in force, `tlb_hit` is 1 and `tlb_perm_ok` is 1, then `pa_valid` pulses one cycle later. `pa[AW-1:12]` equals `tlb_pbase + (req_addr[AW-1:12] - tlb_vbase)`, taken modulo the page-number width, and `pa[11:0]` equals `req_addr[11:0]`.
- R4: On a fault, `ear` is loaded with the full faulting request address.
- R5: A fault with `tlb_hit`=1 and `tlb_perm_ok`=0 (a permission violation) gives code 16 in `esr[4:0]`. A fault with `tlb_hit`=0 (a lookup miss) gives code 18. A fetch (`req_kind`=2) adds 1 to either code, giving 17 or 19. `req_kind` 0 is a load, 1 is a store and 3 behaves as a load. All `esr` bits other than [4:0] and 10 are 0.
- R6: `esr[10]` is 1 exactly when the faulting request was a store.
- R7: `fault` is a single-cycle pulse one cycle after each faulting request. `esr` and `ear` change only on such a pulse and otherwise hold their value.
- R8: If a fault arises while `fault_pending` is 1, `dbl_fault` pulses one cycle later instead of `fault`, and `esr` and `ear` are left unchanged.
- R9: Synchronous reset clears `pa_valid`, `pa`, `fault`, `dbl_fault`, `esr` and `ear` to 0. Without `req_valid`, none of the pulses occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_addr | input | AW | Virtual request address |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 as load |
| cfg_mmu_present | input | 1 | Core configured with translation hardware |
| cfg_full_set | input | 1 | Extended configuration set is implemented |
| cfg_xlat_field | input | 2 | Extended configuration translation field; 2'b11 means in use |
| msr_vm | input | 1 | Machine-state virtual-mode bit |
| tlb_hit | input | 1 | Lookup found a matching entry |
| tlb_perm_ok | input | 1 | Matching entry permits this access |
| tlb_vbase | input | AW-12 | Virtual page number of the matching entry |
| tlb_pbase | input | AW-12 | Physical page number of the matching entry |
| fault_pending | input | 1 | A memory-management exception is already pending |
| pa_valid | output | 1 | Physical address valid pulse |
| pa | output | AW | Physical address |
| fault | output | 1 | Memory-management exception pulse |
| dbl_fault | output | 1 | Unrecoverable double-fault pulse |
| esr | output | 32 | Exception syndrome word |
| ear | output | AW | Faulting address |

## Verification
Every result of this unit comes out of a single register stage. `pa_valid`, `pa`, `fault` and `dbl_fault` for a request presented in one cycle are visible during the next cycle only. `esr` and `ear` change at that same edge and then hold. The bench drives each request on a falling edge and checks the outcome on the following falling edge, after exactly one rising edge. Back-to-back requests are driven at that same falling edge, so the hold behaviour of the syndrome registers is checked across consecutive non-faulting requests.

// File: rtl/mmu_fault_pkg.sv
package mmu_fault_pkg;

    localparam int ESR_W     = 32;
    localparam int STORE_BIT = 10;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    localparam logic [4:0] CODE_PERM = 5'd16;
    localparam logic [4:0] CODE_MISS = 5'd18;

    // Syndrome word for a faulting access
    function automatic logic [ESR_W-1:0] make_esr(input logic miss, input acc_e kind);
        logic [ESR_W-1:0] w;
        w = '0;
        w[4:0] = (miss ? CODE_MISS : CODE_PERM) + ((kind == ACC_FETCH) ? 5'd1 : 5'd0);
        w[STORE_BIT] = (kind == ACC_STORE);
        return w;
    endfunction

endpackage

// File: rtl/mmu_xlat_gate.sv
module mmu_xlat_gate (
    input  logic       cfg_mmu_present,
    input  logic       cfg_full_set,
    input  logic [1:0] cfg_xlat_field,
    input  logic       msr_vm,
    output logic       xlat_on
);
    logic mmu_possible;

    always_comb begin
        mmu_possible = cfg_mmu_present && (!cfg_full_set || (cfg_xlat_field == 2'b11));
        xlat_on      = mmu_possible && msr_vm;
    end

    // R1: translation never claimed without the virtual-mode bit
    always_comb begin
        a_r1_needs_vm: assert (!xlat_on || msr_vm);
    end
endmodule

// File: rtl/mmu_page_map.sv
module mmu_page_map #(
    parameter int AW = 32,
    parameter int PB = 12
) (
    input  logic [AW-1:0]    va,
    input  logic             xlat_on,
    input  logic [AW-PB-1:0] vbase,
    input  logic [AW-PB-1:0] pbase,
    output logic [AW-1:0]    pa
);
    localparam int VW = AW - PB;

    logic [VW-1:0] vpn;
    logic [VW-1:0] ppn;

    always_comb begin
        vpn = va[AW-1:PB];
        ppn = xlat_on ? (pbase + (vpn - vbase)) : vpn;
        pa  = {ppn, va[PB-1:0]};
    end

    // R3: page offset is never altered
    always_comb begin
        a_r3_offset_kept: assert (pa[PB-1:0] == va[PB-1:0]);
    end
endmodule

// File: rtl/mmu_syndrome.sv
module mmu_syndrome
    import mmu_fault_pkg::*;
(
    input  logic             req_valid,
    input  logic             xlat_on,
    input  logic             tlb_hit,
    input  logic             tlb_perm_ok,
    input  logic             fault_pending,
    input  acc_e             kind,
    output logic             pass_now,
    output logic             fault_now,
    output logic             dbl_now,
    output logic [ESR_W-1:0] esr_next
);
    logic bad;

    always_comb begin
        bad       = req_valid && xlat_on && !(tlb_hit && tlb_perm_ok);
        pass_now  = req_valid && !bad;
        fault_now = bad && !fault_pending;
        dbl_now   = bad && fault_pending;
        esr_next  = make_esr(!tlb_hit, kind);
    end

    // R8: at most one outcome per request
    always_comb begin
        a_r8_one_outcome: assert ($onehot0({pass_now, fault_now, dbl_now}));
    end
endmodule

// File: rtl/mmu_fault_gen.sv
module mmu_fault_gen
    import mmu_fault_pkg::*;
#(
    parameter int AW = 32,
    parameter int PB = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    input  logic [1:0]       req_kind,
    input  logic             cfg_mmu_present,
    input  logic             cfg_full_set,
    input  logic [1:0]       cfg_xlat_field,
    input  logic             msr_vm,
    input  logic             tlb_hit,
    input  logic             tlb_perm_ok,
    input  logic [AW-PB-1:0] tlb_vbase,
    input  logic [AW-PB-1:0] tlb_pbase,
    input  logic             fault_pending,
    output logic             pa_valid,
    output logic [AW-1:0]    pa,
    output logic             fault,
    output logic             dbl_fault,
    output logic [ESR_W-1:0] esr,
    output logic [AW-1:0]    ear
);
    logic             xlat_on;
    logic [AW-1:0]    pa_comb;
    logic             pass_now, fault_now, dbl_now;
    logic [ESR_W-1:0] esr_next;
    acc_e             kind;

    assign kind = acc_e'(req_kind);

    mmu_xlat_gate u_gate (
        .cfg_mmu_present (cfg_mmu_present),
        .cfg_full_set    (cfg_full_set),
        .cfg_xlat_field  (cfg_xlat_field),
        .msr_vm          (msr_vm),
        .xlat_on         (xlat_on)
    );

    mmu_page_map #(.AW(AW), .PB(PB)) u_map (
        .va      (req_addr),
        .xlat_on (xlat_on),
        .vbase   (tlb_vbase),
        .pbase   (tlb_pbase),
        .pa      (pa_comb)
    );

    mmu_syndrome u_syn (
        .req_valid     (req_valid),
        .xlat_on       (xlat_on),
        .tlb_hit       (tlb_hit),
        .tlb_perm_ok   (tlb_perm_ok),
        .fault_pending (fault_pending),
        .kind          (kind),
        .pass_now      (pass_now),
        .fault_now     (fault_now),
        .dbl_now       (dbl_now),
        .esr_next      (esr_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pa_valid  <= 1'b0;
            pa        <= '0;
            fault     <= 1'b0;
            dbl_fault <= 1'b0;
            esr       <= '0;
            ear       <= '0;
        end else begin
            pa_valid  <= pass_now;
            fault     <= fault_now;
            dbl_fault <= dbl_now;
            if (pass_now) pa <= pa_comb;
            if (fault_now) begin
                esr <= esr_next;
                ear <= req_addr;
            end
        end
    end

    a_r4_ear_is_addr: assert property (@(posedge clk) disable iff (rst)
        fault |-> ear == $past(req_addr));
    a_r6_store_flag: assert property (@(posedge clk) disable iff (rst)
        fault |-> esr[STORE_BIT] == ($past(req_kind) == 2'd1));
    a_r7_syndrome_hold: assert property (@(posedge clk) disable iff (rst)
        !fault |-> ($stable(esr) && $stable(ear)));
    a_r8_dbl_not_fault: assert property (@(posedge clk) disable iff (rst)
        !(fault && dbl_fault));
    a_r2_bypass_addr: assert property (@(posedge clk) disable iff (rst)
        (pa_valid && !$past(msr_vm)) |-> pa == $past(req_addr));
    a_r9_no_req_no_pulse: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !(pa_valid || fault || dbl_fault));
endmodule

// File: tb/mmu_fault_gen_tb.sv
module mmu_fault_gen_tb;
    localparam int AW = 32;
    localparam int PB = 12;
    localparam int VW = AW - PB;

    logic          clk = 0;
    logic          rst;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic [1:0]    req_kind;
    logic          cfg_mmu_present, cfg_full_set, msr_vm;
    logic [1:0]    cfg_xlat_field;
    logic          tlb_hit, tlb_perm_ok, fault_pending;
    logic [VW-1:0] tlb_vbase, tlb_pbase;
    logic          pa_valid, fault, dbl_fault;
    logic [AW-1:0] pa, ear;
    logic [31:0]   esr;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [31:0]   exp_esr;
    logic [AW-1:0] exp_ear;

    always #5 clk = ~clk;

    mmu_fault_gen u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .cfg_mmu_present(cfg_mmu_present),
        .cfg_full_set(cfg_full_set), .cfg_xlat_field(cfg_xlat_field),
        .msr_vm(msr_vm), .tlb_hit(tlb_hit), .tlb_perm_ok(tlb_perm_ok),
        .tlb_vbase(tlb_vbase), .tlb_pbase(tlb_pbase),
        .fault_pending(fault_pending), .pa_valid(pa_valid), .pa(pa),
        .fault(fault), .dbl_fault(dbl_fault), .esr(esr), .ear(ear)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit x_on(input bit pres, input bit full, input logic [1:0] fld, input bit vm);
        return pres && (!full || fld == 2'b11) && vm;
    endfunction

    function automatic logic [31:0] syn_word(input bit miss, input logic [1:0] k);
        logic [31:0] w = 0;
        w[4:0] = miss ? 5'd18 : 5'd16;
        if (k == 2'd2) w[4:0] = w[4:0] + 5'd1;
        w[10] = (k == 2'd1);
        return w;
    endfunction

    // Drive one request at a falling edge, check at the next falling edge
    task automatic one_req(input logic [AW-1:0] a, input logic [1:0] k,
                           input bit pres, input bit full, input logic [1:0] fld, input bit vm,
                           input bit hit, input bit perm, input logic [VW-1:0] vb,
                           input logic [VW-1:0] pb, input bit pend);
        bit on, bad;
        logic [AW-1:0] epa;
        req_valid = 1; req_addr = a; req_kind = k; cfg_mmu_present = pres;
        cfg_full_set = full; cfg_xlat_field = fld; msr_vm = vm; tlb_hit = hit;
        tlb_perm_ok = perm; tlb_vbase = vb; tlb_pbase = pb; fault_pending = pend;
        on  = x_on(pres, full, fld, vm);
        bad = on && !(hit && perm);
        epa = on ? {pb + (a[AW-1:PB] - vb), a[PB-1:0]} : a;
        if (bad && !pend) begin
            exp_esr = syn_word(!hit, k);
            exp_ear = a;
        end
        @(negedge clk);
        req_valid = 0;
        chk("R1/R2/R3 pa_valid", 64'(pa_valid), 64'(!bad));
        if (!bad) chk(on ? "R3 pa translated" : "R2 pa bypass", 64'(pa), 64'(epa));
        chk("R7 fault pulse", 64'(fault), 64'(bad && !pend));
        chk("R8 dbl_fault", 64'(dbl_fault), 64'(bad && pend));
        chk("R5/R6 esr", 64'(esr), 64'(exp_esr));
        chk("R4 ear", 64'(ear), 64'(exp_ear));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; req_valid = 0; req_addr = 0; req_kind = 0; cfg_mmu_present = 0;
        cfg_full_set = 0; cfg_xlat_field = 0; msr_vm = 0; tlb_hit = 0;
        tlb_perm_ok = 0; tlb_vbase = 0; tlb_pbase = 0; fault_pending = 0;
        exp_esr = 0; exp_ear = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R9 reset state
        chk("R9 reset pa_valid", 64'(pa_valid), 0);
        chk("R9 reset fault", 64'(fault), 0);
        chk("R9 reset dbl", 64'(dbl_fault), 0);
        chk("R9 reset esr", 64'(esr), 0);
        chk("R9 reset ear", 64'(ear), 0);
        chk("R9 reset pa", 64'(pa), 0);

        // R2 bypass with vm off although lookup misses
        one_req(32'hABCD_E123, 2'd0, 1, 0, 2'b00, 0, 0, 0, 20'h0, 20'h0, 0);
        // R1 full set with field not in use: bypass
        one_req(32'h1234_5678, 2'd1, 1, 1, 2'b01, 1, 0, 0, 20'h0, 20'h0, 0);
        // R1 not present: bypass
        one_req(32'h0000_0FFF, 2'd2, 0, 0, 2'b11, 1, 0, 0, 20'h0, 20'h0, 0);
        // R3 hit, wraparound page arithmetic
        one_req(32'h0000_1ABC, 2'd0, 1, 1, 2'b11, 1, 1, 1, 20'h00002, 20'h00000, 0);
        // R5 permission violation on fetch -> 17
        one_req(32'h8000_0004, 2'd2, 1, 0, 2'b00, 1, 1, 0, 20'h0, 20'h0, 0);
        chk("R5 code 17", 64'(esr[4:0]), 17);
        // R7 hold across a clean request
        one_req(32'h0000_2000, 2'd1, 1, 0, 2'b00, 0, 0, 0, 20'h0, 20'h0, 0);
        // R6 miss store -> 18 with bit 10
        one_req(32'hDEAD_BEEF, 2'd1, 1, 0, 2'b00, 1, 0, 0, 20'h0, 20'h0, 0);
        chk("R6 store bit", 64'(esr[10]), 1);
        // R5 miss fetch -> 19
        one_req(32'hFFFF_FFFF, 2'd2, 1, 0, 2'b00, 1, 0, 1, 20'h0, 20'h0, 0);
        chk("R5 code 19", 64'(esr), 19);
        // R8 fault while pending: esr/ear unchanged
        one_req(32'h5555_0000, 2'd0, 1, 0, 2'b00, 1, 0, 0, 20'h0, 20'h0, 1);
        // R5 reserved kind behaves as load on a permission fault -> 16
        one_req(32'h4444_4444, 2'd3, 1, 0, 2'b00, 1, 1, 0, 20'h0, 20'h0, 0);
        chk("R5 code 16", 64'(esr), 16);
        // R9 idle: no pulse
        @(negedge clk);
        chk("R9 idle no pulse", 64'({pa_valid, fault, dbl_fault}), 0);

        for (int i = 0; i < 400; i++) begin
            one_req($urandom, 2'($urandom), 1'($urandom), 1'($urandom),
                    2'($urandom), ($urandom % 4) != 0, 1'($urandom), ($urandom % 3) != 0,
                    20'($urandom), 20'($urandom), ($urandom % 5) == 0);
        end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule